// File: doc/BRIEF.md
# Debounced Push-Button Control Unit

This block turns five raw mechanical push-button inputs into clean control signals for a small test system. Each button is first brought into the clock domain by a synchronizer. A debouncer then filters out contact bounce, and an edge detector turns each accepted press into a strobe that lasts one clock cycle. One press therefore yields exactly one pulse, however long the button is held and however much it bounces.

Four of the buttons drive one-shot strobes: left gives `load_a`, right gives `load_b`, up gives `step` and down gives `next_out`. The centre button drives no strobe of its own. Its pulse sets a sticky `run` flag that stays high until the next reset.

The filter length `HOLD_CYCLES` is a parameter. Its default, 2^20 cycles, is about 10.5 ms at 100 MHz.

Top module: `btn_ctrl_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `load_a`, `load_b`, `step`, `next_out` and `run` are all 0.
- R2: The left button drives `load_a`, the right button `load_b`, the up button `step` and the down button `next_out`. A press on one button produces no pulse on the other three strobes.
- R3: Every strobe is high for exactly one clock cycle per accepted press.
- R4: Holding a button yields a single pulse. Releasing it yields none. A new press after an accepted release yields a new pulse.
- R5: A new button level is accepted only after the synchronized input has differed from the accepted level for `HOLD_CYCLES` consecutive clock cycles. Any shorter excursion is ignored.
- R6: Suppose a raw button input changes between two clock edges and then holds steady. Its strobe is 0 after rising edge `HOLD_CYCLES`+2 and is 1 after rising edge `HOLD_CYCLES`+3, counting edges from the change.
- R7: An accepted centre press sets `run` one cycle after the internal centre pulse. `run` then stays 1 through any later presses and releases, and only `rst` clears it.
- R8: A centre press produces no pulse on any of the four strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_left | input | 1 | Raw left button, asynchronous |
| btn_right | input | 1 | Raw right button, asynchronous |
| btn_up | input | 1 | Raw up button, asynchronous |
| btn_down | input | 1 | Raw down button, asynchronous |
| btn_center | input | 1 | Raw centre button, asynchronous |
| load_a | output | 1 | One-cycle strobe from the left button |
| load_b | output | 1 | One-cycle strobe from the right button |
| step | output | 1 | One-cycle strobe from the up button |
| next_out | output | 1 | One-cycle strobe from the down button |
| run | output | 1 | Sticky run flag set by the centre button |

## Verification
The assertions check four properties on every cycle:
- the reset clearing of all outputs;
- the single-cycle width of each strobe;
- that `run` never falls outside reset;
- that `run` rises only after a centre pulse.

Other behaviours depend on the stimulus history, and only the bench's scenarios can show them:
- the filter threshold, shown with glitches just shorter than `HOLD_CYCLES` and with bounce trains;
- the exact press-to-strobe latency;
- the single pulse per long hold, and silence on release;
- the mapping of each button to its strobe.

// File: rtl/btn_ctrl_pkg.sv
package btn_ctrl_pkg;
  localparam int NUM_BTNS   = 5;
  localparam int IDX_LEFT   = 0;
  localparam int IDX_RIGHT  = 1;
  localparam int IDX_UP     = 2;
  localparam int IDX_DOWN   = 3;
  localparam int IDX_CENTER = 4;
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '0;
    else     chain_q <= {chain_q[STAGES-2:0], raw_in};
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int HOLD_CYCLES = 1 << 20
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic level_out
);
  localparam int CW = (HOLD_CYCLES > 2) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LIMIT = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] run_len_q;
  logic          accepted_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      accepted_q <= 1'b0;
      run_len_q  <= '0;
    end else if (level_in == accepted_q) begin
      run_len_q  <= '0;
    end else if (run_len_q == LIMIT) begin
      accepted_q <= level_in;
      run_len_q  <= '0;
    end else begin
      run_len_q  <= run_len_q + 1'b1;
    end
  end

  assign level_out = accepted_q;
endmodule

// File: rtl/btn_rise.sv
module btn_rise (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic pulse_out
);
  logic prev_q;
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= level_in;
      pulse_q <= level_in & ~prev_q;
    end
  end

  assign pulse_out = pulse_q;
endmodule

// File: rtl/btn_ctrl_unit.sv
module btn_ctrl_unit
  import btn_ctrl_pkg::*;
#(
  parameter int HOLD_CYCLES = 1 << 20,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_left,
  input  logic btn_right,
  input  logic btn_up,
  input  logic btn_down,
  input  logic btn_center,
  output logic load_a,
  output logic load_b,
  output logic step,
  output logic next_out,
  output logic run
);
  logic [NUM_BTNS-1:0] raw_vec;
  logic [NUM_BTNS-1:0] synced;
  logic [NUM_BTNS-1:0] clean;
  logic [NUM_BTNS-1:0] edge_pulse;
  logic                center_strobe;
  logic                run_q;

  assign raw_vec[IDX_LEFT]   = btn_left;
  assign raw_vec[IDX_RIGHT]  = btn_right;
  assign raw_vec[IDX_UP]     = btn_up;
  assign raw_vec[IDX_DOWN]   = btn_down;
  assign raw_vec[IDX_CENTER] = btn_center;

  for (genvar i = 0; i < NUM_BTNS; i++) begin : g_chan
    btn_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .raw_in(raw_vec[i]), .sync_out(synced[i])
    );
    btn_debounce #(.HOLD_CYCLES(HOLD_CYCLES)) u_deb (
      .clk(clk), .rst(rst), .level_in(synced[i]), .level_out(clean[i])
    );
    btn_rise u_rise (
      .clk(clk), .rst(rst), .level_in(clean[i]), .pulse_out(edge_pulse[i])
    );
  end

  assign center_strobe = edge_pulse[IDX_CENTER];

  // Sticky mode flag: data is constant one, enable is the centre strobe.
  always_ff @(posedge clk) begin
    if (rst)                run_q <= 1'b0;
    else if (center_strobe) run_q <= 1'b1;
  end

  assign load_a   = edge_pulse[IDX_LEFT];
  assign load_b   = edge_pulse[IDX_RIGHT];
  assign step     = edge_pulse[IDX_UP];
  assign next_out = edge_pulse[IDX_DOWN];
  assign run      = run_q;
endmodule

// File: rtl/btn_ctrl_unit_chk.sv
module btn_ctrl_unit_chk (
  input logic clk,
  input logic rst,
  input logic load_a,
  input logic load_b,
  input logic step,
  input logic next_out,
  input logic run,
  input logic center_strobe
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!load_a && !load_b && !step && !next_out && !run));

  assert_one_cycle_a_R3: assert property (@(posedge clk) disable iff (rst)
    load_a |=> !load_a);
  assert_one_cycle_b_R3: assert property (@(posedge clk) disable iff (rst)
    load_b |=> !load_b);
  assert_one_cycle_step_R3: assert property (@(posedge clk) disable iff (rst)
    step |=> !step);
  assert_one_cycle_next_R3: assert property (@(posedge clk) disable iff (rst)
    next_out |=> !next_out);

  assert_run_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    run |=> run);
  assert_run_set_R7: assert property (@(posedge clk) disable iff (rst)
    center_strobe |=> run);
  assert_run_cause_R7: assert property (@(posedge clk) disable iff (rst)
    (!run ##1 run) |-> $past(center_strobe));
endmodule

bind btn_ctrl_unit btn_ctrl_unit_chk u_chk (
  .clk(clk), .rst(rst), .load_a(load_a), .load_b(load_b), .step(step),
  .next_out(next_out), .run(run), .center_strobe(center_strobe)
);

// File: tb/btn_ctrl_unit_test.sv
`timescale 1ns/1ps
module btn_ctrl_unit_test;
  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] btn = '0;  // 0 left, 1 right, 2 up, 3 down, 4 centre
  logic load_a, load_b, step, next_out, run;

  int checks = 0;
  int failures = 0;
  int cnt [4];
  int wide;
  logic [3:0] prev_s = '0;

  always #2.5 clk = ~clk;

  btn_ctrl_unit #(.HOLD_CYCLES(HOLD)) uut (
    .clk(clk), .rst(rst),
    .btn_left(btn[0]), .btn_right(btn[1]), .btn_up(btn[2]),
    .btn_down(btn[3]), .btn_center(btn[4]),
    .load_a(load_a), .load_b(load_b), .step(step),
    .next_out(next_out), .run(run)
  );

  // Sample away from the active edge: count pulses and overlong pulses.
  always @(negedge clk) begin
    logic [3:0] s;
    s = {next_out, step, load_b, load_a};
    for (int i = 0; i < 4; i++) begin
      if (s[i] && !prev_s[i]) cnt[i]++;
      if (s[i] && prev_s[i]) wide++;
    end
    prev_s = s;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_counts();
    for (int i = 0; i < 4; i++) cnt[i] = 0;
    wide = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    btn = '0;
    wait_cyc(4);
    check("R1 outputs in reset", {load_a, load_b, step, next_out, run}, 0);
    rst = 1'b0;
    wait_cyc(1);
    check("R1 outputs after reset", {load_a, load_b, step, next_out, run}, 0);
  endtask

  // Press one strobe button, hold long, release; check mapping and count.
  task automatic t_press_map(input int idx);
    clear_counts();
    btn[idx] = 1'b1;
    wait_cyc(5 * HOLD);
    btn[idx] = 1'b0;
    wait_cyc(3 * HOLD);
    for (int i = 0; i < 4; i++)
      check($sformatf("R2 R4 button %0d strobe %0d count", idx, i), cnt[i], (i == idx) ? 1 : 0);
    check("R3 strobe width", wide, 0);
  endtask

  task automatic t_latency();
    clear_counts();
    btn[0] = 1'b1;
    wait_cyc(HOLD + 2);
    check("R6 strobe not yet", load_a, 0);
    wait_cyc(1);
    check("R6 strobe on time", load_a, 1);
    wait_cyc(1);
    check("R3 strobe drops", load_a, 0);
    wait_cyc(2 * HOLD);
    btn[0] = 1'b0;
    wait_cyc(3 * HOLD);
    check("R4 release gives no pulse", cnt[0], 1);
  endtask

  task automatic t_glitch();
    clear_counts();
    for (int k = 0; k < 4; k++) begin
      btn[1] = 1'b1;
      wait_cyc(HOLD - 2);
      btn[1] = 1'b0;
      wait_cyc(2);
    end
    wait_cyc(3 * HOLD);
    check("R5 short glitches ignored", cnt[1], 0);
  endtask

  task automatic t_bounce();
    clear_counts();
    for (int k = 1; k < 6; k++) begin
      btn[2] = 1'b1; wait_cyc(k);
      btn[2] = 1'b0; wait_cyc(1);
    end
    btn[2] = 1'b1;
    wait_cyc(4 * HOLD);
    for (int k = 1; k < 5; k++) begin
      btn[2] = 1'b0; wait_cyc(k);
      btn[2] = 1'b1; wait_cyc(1);
    end
    btn[2] = 1'b0;
    wait_cyc(3 * HOLD);
    check("R5 bounce gives one pulse", cnt[2], 1);
  endtask

  task automatic t_repress();
    clear_counts();
    for (int k = 0; k < 3; k++) begin
      btn[3] = 1'b1; wait_cyc(2 * HOLD);
      btn[3] = 1'b0; wait_cyc(2 * HOLD);
    end
    check("R4 three presses three pulses", cnt[3], 3);
    check("R3 width on repress", wide, 0);
  endtask

  task automatic t_run();
    clear_counts();
    check("R7 run low before centre", run, 0);
    btn[4] = 1'b1;
    wait_cyc(HOLD + 3);
    check("R7 run not yet set", run, 0);
    wait_cyc(1);
    check("R7 run set one cycle after pulse", run, 1);
    wait_cyc(2 * HOLD);
    btn[4] = 1'b0;
    wait_cyc(3 * HOLD);
    check("R7 run held after release", run, 1);
    btn[4] = 1'b1; wait_cyc(2 * HOLD);
    btn[4] = 1'b0; wait_cyc(2 * HOLD);
    check("R7 run held after second press", run, 1);
    check("R8 centre makes no strobe", cnt[0] + cnt[1] + cnt[2] + cnt[3], 0);
    rst = 1'b1; wait_cyc(2);
    rst = 1'b0; wait_cyc(1);
    check("R7 run cleared by reset", run, 0);
  endtask

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    clear_counts();
    wait_cyc(1);
    t_reset();
    for (int i = 0; i < 4; i++) t_press_map(i);
    t_latency();
    t_glitch();
    t_bounce();
    t_repress();
    t_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule